// File: doc/BRIEF.md
# Hamming Code Syndrome Checker for 256-Byte Flash Chunks

This block judges one 256-byte chunk of flash data after a read. It takes two 24-bit check codes: the one just computed over the data that came back, and the one that was stored beside the data when it was written. Their bitwise XOR is the syndrome. The number of ones in the syndrome sets the verdict. No ones means the data is clean. One one means the stored code itself took the hit. Eleven ones means a single data bit flipped, and the odd-numbered syndrome bits give its location. Any other count is beyond repair.

A controller pulses `start_i` with both codes present. One cycle later the verdict and the location are registered and `done_o` pulses. The result holds until the next start. To repair a buffer, the controller presents a byte offset on `probe_addr_i` and XORs the returned `flip_mask_o` into that byte. The mask is nonzero only for the one byte that needs fixing.

Top module: `hamming_syndrome_chk`

## Requirements
- R1: Each code is 24 bits: byte 0 in bits [7:0], byte 1 in [15:8], byte 2 in [23:16]. The syndrome is `calc_code_i ^ read_code_i`. A one-cycle `start_i` at clock edge k gives a one-cycle `done_o` after edge k+1, with the new result on the outputs at the same time.
- R2: A syndrome of all zeros reports status 0 (clean).
- R3: A syndrome with exactly 11 ones reports status 1 (corrected). `byte_addr_o` is error address bits [10:3] and `bit_idx_o` is error address bits [2:0].
- R4: The error address is built from the odd syndrome bits as follows. Address bits 0, 1 and 2 are syndrome byte 0 bits 3, 5 and 7. Address bits 3 to 6 are syndrome byte 2 bits 1, 3, 5 and 7. Address bits 7 to 10 are syndrome byte 1 bits 1, 3, 5 and 7.
- R5: A syndrome with exactly one 1 reports status 2 (stored code damaged, data intact). For every status other than 1, `byte_addr_o` and `bit_idx_o` are zero.
- R6: Any other nonzero count of ones (2 to 10, or 12 to 24) reports status 3 (uncorrectable).
- R7: While `start_i` is low, `status_o`, `byte_addr_o` and `bit_idx_o` keep their values and `done_o` is low.
- R8: `flip_mask_o` is combinational from `probe_addr_i` and the held result. It has a single one at bit `bit_idx_o` when the status is 1 and `probe_addr_i` equals `byte_addr_o`. In every other case it is zero.
- R9: A synchronous active-high `rst` clears the status to 0, both address outputs to 0 and `done_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Evaluate the presented codes |
| calc_code_i | input | 24 | Code computed over the data read back |
| read_code_i | input | 24 | Code read back from storage |
| status_o | output | 2 | 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable |
| byte_addr_o | output | 8 | Offset of the byte holding the bad bit |
| bit_idx_o | output | 3 | Position of the bad bit inside that byte |
| done_o | output | 1 | One-cycle pulse when a new result is on the outputs |
| probe_addr_i | input | 8 | Byte offset queried for a repair mask |
| flip_mask_o | output | 8 | XOR mask for the queried byte |

## Verification
The assertions take the codes as meaningful only in the cycle that `start_i` is high. They assume reset lasts at least one clock edge. They also assume `start_i` is never treated as a level that spans several results; a new start simply replaces the result. The stimulus changes codes and probe offsets only just after a rising edge. It mixes single starts, back-to-back starts and idle gaps. The syndromes it builds cover every single-bit position and the true single-data-bit patterns, including byte 0 bit 0 and byte 255 bit 7. It also uses eleven-one patterns that are not valid codes, plus 2-, 3-, 12- and 24-one counts, so every status value and the hold behaviour are exercised.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

    localparam int CODE_W   = 24;
    localparam int ADDR_W   = 11;
    localparam int BIT_W    = 3;
    localparam int OFF_W    = ADDR_W - BIT_W;
    localparam int CNT_W    = $clog2(CODE_W + 1);
    localparam int FIX_ONES = ADDR_W;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXED    = 2'd1,
        ST_CODE_BAD = 2'd2,
        ST_FATAL    = 2'd3
    } chk_status_e;

    typedef struct packed {
        logic [OFF_W-1:0] byte_off;
        logic [BIT_W-1:0] bit_pos;
    } flip_loc_t;

    function automatic chk_status_e classify(input logic [CNT_W-1:0] ones);
        if (ones == '0)
            return ST_CLEAN;
        else if (ones == CNT_W'(1))
            return ST_CODE_BAD;
        else if (ones == CNT_W'(FIX_ONES))
            return ST_FIXED;
        else
            return ST_FATAL;
    endfunction

endpackage

// File: rtl/ecc_bit_counter.sv
module ecc_bit_counter #(
    parameter int W     = 24,
    parameter int CW    = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] ones_o
);
    localparam int LVLS = $clog2(W);
    localparam int NPAD = 1 << LVLS;

    // heap layout: node n sums nodes 2n and 2n+1, leaves sit at NPAD..2*NPAD-1
    logic [CW-1:0] node [1:2*NPAD-1];

    for (genvar i = 0; i < NPAD; i++) begin : g_leaf
        if (i < W) begin : g_real
            assign node[NPAD+i] = {{(CW-1){1'b0}}, vec_i[i]};
        end else begin : g_pad
            assign node[NPAD+i] = '0;
        end
    end

    for (genvar n = 1; n < NPAD; n++) begin : g_sum
        assign node[n] = node[2*n] + node[2*n+1];
    end

    assign ones_o = node[1];

endmodule

// File: rtl/ecc_locator.sv
module ecc_locator
    import ecc_chk_pkg::*;
(
    input  logic [CODE_W-1:0] syn_i,
    output flip_loc_t         loc_o
);
    logic [ADDR_W-1:0] addr;

    // low three address bits: odd pair members 3,5,7 of byte 0
    for (genvar j = 0; j < 3; j++) begin : g_lo
        assign addr[j] = syn_i[3 + 2*j];
    end
    // middle from byte 2, top from byte 1, odd bits 1,3,5,7 each
    for (genvar j = 0; j < 4; j++) begin : g_hi
        assign addr[3 + j] = syn_i[16 + 1 + 2*j];
        assign addr[7 + j] = syn_i[8 + 1 + 2*j];
    end

    assign loc_o = flip_loc_t'(addr);

    logic unused_even;
    assign unused_even = ^{syn_i[0], syn_i[1], syn_i[2], syn_i[4], syn_i[6],
                           syn_i[8], syn_i[10], syn_i[12], syn_i[14],
                           syn_i[16], syn_i[18], syn_i[20], syn_i[22]};

endmodule

// File: rtl/hamming_syndrome_chk.sv
module hamming_syndrome_chk
    import ecc_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] calc_code_i,
    input  logic [CODE_W-1:0] read_code_i,
    output logic [1:0]        status_o,
    output logic [OFF_W-1:0]  byte_addr_o,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic              done_o,
    input  logic [OFF_W-1:0]  probe_addr_i,
    output logic [7:0]        flip_mask_o
);
    logic [CODE_W-1:0] syn;
    logic [CNT_W-1:0]  ones;
    flip_loc_t         loc_d;
    chk_status_e       verdict;

    chk_status_e       status_q;
    flip_loc_t         loc_q;
    logic              done_q;

    assign syn = calc_code_i ^ read_code_i;

    ecc_bit_counter #(.W(CODE_W), .CW(CNT_W)) u_count (
        .vec_i  (syn),
        .ones_o (ones)
    );

    ecc_locator u_loc (
        .syn_i (syn),
        .loc_o (loc_d)
    );

    assign verdict = classify(ones);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= ST_CLEAN;
            loc_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= start_i;
            if (start_i) begin
                status_q <= verdict;
                loc_q    <= (verdict == ST_FIXED) ? loc_d : '0;
            end
        end
    end

    assign status_o    = status_q;
    assign byte_addr_o = loc_q.byte_off;
    assign bit_idx_o   = loc_q.bit_pos;
    assign done_o      = done_q;

    logic hit;
    assign hit = (status_q == ST_FIXED) && (probe_addr_i == loc_q.byte_off);

    for (genvar b = 0; b < 8; b++) begin : g_mask
        assign flip_mask_o[b] = hit && (loc_q.bit_pos == BIT_W'(b));
    end

    // R1: a start yields a done pulse on the next cycle
    p_done_follows_start_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    // R7: no start means no done and a held result
    p_idle_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);
    p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(status_o) && $stable(byte_addr_o) && $stable(bit_idx_o)));

    // R2: matching codes give a clean verdict
    p_match_clean_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && (calc_code_i == read_code_i)) |=> (status_o == 2'd0));

    // R5: a lone differing bit blames the stored code
    p_single_code_r5: assert property (@(posedge clk) disable iff (rst)
        (start_i && ($countones(calc_code_i ^ read_code_i) == 1)) |=> (status_o == 2'd2));

    // R5: location outputs are zero unless corrected
    p_loc_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (status_o != 2'd1) |-> (byte_addr_o == '0 && bit_idx_o == '0));

    // R8: a nonzero mask is a single bit and only under a corrected verdict
    p_mask_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        (flip_mask_o != '0) |-> (status_o == 2'd1 && $countones(flip_mask_o) == 1
                                 && probe_addr_i == byte_addr_o));

endmodule

// File: tb/hamming_syndrome_chk_test.sv
module hamming_syndrome_chk_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] calc_code_i = '0;
    logic [23:0] read_code_i = '0;
    logic [7:0]  probe_addr_i = '0;
    logic [1:0]  status_o;
    logic [7:0]  byte_addr_o;
    logic [2:0]  bit_idx_o;
    logic        done_o;
    logic [7:0]  flip_mask_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    hamming_syndrome_chk uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .calc_code_i  (calc_code_i),
        .read_code_i  (read_code_i),
        .status_o     (status_o),
        .byte_addr_o  (byte_addr_o),
        .bit_idx_o    (bit_idx_o),
        .done_o       (done_o),
        .probe_addr_i (probe_addr_i),
        .flip_mask_o  (flip_mask_o)
    );

    // behavioural reference state
    int  m_status = 0;
    int  m_byte   = 0;
    int  m_bit    = 0;
    bit  m_done   = 0;
    bit  m_started = 0;

    function automatic int ones_of(input logic [23:0] v);
        int n = 0;
        for (int i = 0; i < 24; i++) if (v[i]) n++;
        return n;
    endfunction

    // R4: error address from the odd syndrome bits
    function automatic int addr_of(input logic [23:0] s);
        int a = 0;
        if (s[3])  a += 1;
        if (s[5])  a += 2;
        if (s[7])  a += 4;
        for (int j = 0; j < 4; j++) begin
            if (s[16 + 2*j + 1]) a += (8 << j);
            if (s[8 + 2*j + 1])  a += (128 << j);
        end
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_status = 0; m_byte = 0; m_bit = 0; m_done = 0;
        end else begin
            m_done = start_i;
            if (start_i) begin
                logic [23:0] s;
                int n;
                int a;
                s = calc_code_i ^ read_code_i;
                n = ones_of(s);
                a = addr_of(s);
                m_started = 1;
                if (n == 0)       m_status = 0;
                else if (n == 1)  m_status = 2;
                else if (n == 11) m_status = 1;
                else              m_status = 3;
                m_byte = (m_status == 1) ? (a >> 3) : 0;
                m_bit  = (m_status == 1) ? (a & 7) : 0;
            end
        end
    end

    function automatic string tag_status(input int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            int em;
            string rs;
            string ra;
            em = (m_status == 1 && int'(probe_addr_i) == m_byte) ? (1 << m_bit) : 0;
            rs = !m_started ? "R9" : (m_done ? tag_status(m_status) : "R7");
            ra = !m_started ? "R9" : (m_done ? "R4" : "R7");
            check(m_done ? "R1" : (m_started ? "R7" : "R9"), int'(done_o), int'(m_done));
            check(rs, int'(status_o), m_status);
            check(ra, int'(byte_addr_o), m_byte);
            check(ra, int'(bit_idx_o), m_bit);
            check("R8", int'(flip_mask_o), em);
        end
    end

    task automatic go(input logic [23:0] calc, input logic [23:0] syn, input logic [7:0] probe);
        @(posedge clk); #2;
        start_i = 1'b1; calc_code_i = calc; read_code_i = calc ^ syn; probe_addr_i = probe;
        @(posedge clk); #2;
        start_i = 1'b0; calc_code_i = $urandom; read_code_i = $urandom;
    endtask

    task automatic idle(input logic [7:0] probe);
        @(posedge clk); #2;
        probe_addr_i = probe; calc_code_i = $urandom; read_code_i = $urandom;
    endtask

    // single data-bit error pattern: one member of each of the 11 bit pairs
    function automatic logic [23:0] data_err(input int byte_off, input int bit_pos);
        logic [23:0] s = '0;
        for (int j = 0; j < 3; j++) s[2 + 2*j + ((bit_pos >> j) & 1)] = 1'b1;
        for (int m = 0; m < 4; m++) begin
            s[16 + 2*m + ((byte_off >> m) & 1)]       = 1'b1;
            s[8 + 2*m + ((byte_off >> (m + 4)) & 1)]  = 1'b1;
        end
        return s;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        idle(8'h00);
        // R2: matching codes
        go(24'h5a3c01, 24'h000000, 8'h00);
        go(24'hffffff, 24'h000000, 8'h11);
        // R5: every lone syndrome bit
        for (int i = 0; i < 24; i++) go($urandom, 24'h1 << i, 8'h00);
        // R3 R4 R8: true single data-bit errors, probing the right and a wrong byte
        go($urandom, data_err(0, 0), 8'h00);
        idle(8'h01);
        go($urandom, data_err(255, 7), 8'hff);
        idle(8'hfe);
        for (int k = 0; k < 20; k++) begin
            int b = $urandom_range(0, 255);
            int t = $urandom_range(0, 7);
            go($urandom, data_err(b, t), 8'(b));
            idle(8'(b ^ 1));
            idle(8'(b));
        end
        // R3: eleven ones that are not a valid pattern still count as corrected
        go($urandom, 24'h0007ff, 8'h00);
        go($urandom, 24'hffe000, 8'hff);
        // R6: other nonzero counts
        go($urandom, 24'h000003, 8'h00);
        go($urandom, 24'h800101, 8'h00);
        go($urandom, 24'h000fff, 8'h00);
        go($urandom, 24'hffffff, 8'h00);
        go($urandom, 24'h0003ff, 8'h00);
        // R7: hold across idle cycles after a corrected result
        go($urandom, data_err(77, 3), 8'd77);
        repeat (5) idle(8'd77);
        // back-to-back starts
        @(posedge clk); #2; start_i = 1'b1; calc_code_i = 24'h123456; read_code_i = 24'h123456 ^ data_err(9, 5);
        @(posedge clk); #2; read_code_i = 24'h123457;
        @(posedge clk); #2; read_code_i = 24'h123456;
        @(posedge clk); #2; start_i = 1'b0;
        repeat (3) idle(8'd9);
        // R9: reset mid-result clears outputs
        go($urandom, data_err(200, 6), 8'd200);
        @(posedge clk); #2; rst = 1'b1; m_started = 0;
        @(posedge clk); #2; rst = 1'b0;
        idle(8'd200);
        idle(8'd0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule